// File: doc/BRIEF.md
# Modular Inverse Unit (Extended Euclid, Non-Restoring Division)

This block derives a private exponent `d` from a public exponent `e` and a totient `phi`, so that `e*d mod phi == 1`. One strobe on `start_i` captures both operands. The unit then runs the extended Euclidean algorithm one step at a time. Every step hands the current dividend and divisor to a sequential non-restoring divider, which returns both a quotient and a remainder.

The quotient advances a signed coefficient pair. The remainder becomes the next divisor. When the remainder reaches zero, the last nonzero remainder is the gcd of the operands. If it equals one, the signed coefficient is folded into the range `[0, phi)` and presented as `d_o`. If it does not equal one, no inverse exists: `err_o` is raised and `d_o` is cleared.

A one-cycle `done_o` pulse marks each result. The operand width `W` is a parameter and defaults to 32.

Top module: `modinv_unit`

## Requirements
- R1: After reset, `done_o`, `err_o` and `d_o` are all zero.
- R2: For `phi >= 2` and `gcd(e, phi) == 1`, the result has `err_o = 0` and a `d_o` with `d_o < phi` and `(e*d_o) mod phi == 1`.
- R3: When `gcd(e, phi) != 1`, the result has `err_o = 1` and `d_o = 0`.
- R4: Each accepted start yields exactly one `done_o` pulse, one cycle wide. `d_o` and `err_o` keep their values until the next result is delivered.
- R5: A `start_i` pulse that arrives while a computation is running is ignored. The result belongs to the operands of the start that was accepted.
- R6: Every division step returns a quotient `q` and a remainder `r` with `dividend = q*divisor + r` and `r < divisor`. The divider spends one cycle per quotient bit and then one correction cycle.
- R7: An exponent larger than or equal to `phi` gives the same result as `e mod phi`.
- R8: `e = 0` with `phi >= 2` reports an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures `e_i` and `phi_i` and begins a computation when the unit is idle |
| e_i | input | W | Public exponent |
| phi_i | input | W | Modulus for the inverse, at least 2 |
| d_o | output | W | Inverse of `e` modulo `phi`, or zero on error |
| done_o | output | 1 | One-cycle pulse when `d_o` and `err_o` are valid |
| err_o | output | 1 | Set when the gcd is not one |

## Verification
The hardest case to reach from the ports is a final coefficient that comes out negative and needs the `phi` correction. The same sweep has to reach long Euclid chains, whose intermediate coefficients come close to the signed register limit. An 8-bit instance is driven over every exponent below each `phi` from 2 to 30. This produces both coefficient signs and every quotient pattern that small moduli allow. Extra runs at `phi` 255 and 254, and with exponents above `phi`, exercise the widest coefficients and a first Euclid step whose quotient is zero. A second start is injected while a computation is running, to show it is dropped.

// File: rtl/modinv_pkg.sv
package modinv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_WAIT, ST_FIN} inv_state_t;
  typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_FIX} div_phase_t;
endpackage

// File: rtl/modinv_nrdiv.sv
module modinv_nrdiv #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         done_o
);
  import modinv_pkg::*;
  localparam int CW = $clog2(W + 1);

  div_phase_t          phase;
  logic signed [W+1:0] p, sh, p_nx, d_ext;
  logic [W-1:0]        q, d_q, n_q;
  logic [CW-1:0]       cnt;

  assign d_ext = $signed({2'b00, d_q});
  assign sh    = {p[W:0], q[W-1]};
  assign p_nx  = p[W+1] ? sh + d_ext : sh - d_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase  <= DV_IDLE;
      p      <= '0;
      q      <= '0;
      d_q    <= '0;
      n_q    <= '0;
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase)
        DV_IDLE: if (start_i) begin
          p     <= '0;
          q     <= dividend_i;
          n_q   <= dividend_i;
          d_q   <= divisor_i;
          cnt   <= CW'(W);
          phase <= DV_RUN;
        end
        DV_RUN: begin
          p   <= p_nx;
          q   <= {q[W-2:0], ~p_nx[W+1]};
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) phase <= DV_FIX;
        end
        DV_FIX: begin
          if (p[W+1]) p <= p + d_ext;  // restore a negative remainder
          done_o <= 1'b1;
          phase  <= DV_IDLE;
        end
        default: phase <= DV_IDLE;
      endcase
    end
  end

  assign quot_o = q;
  assign rem_o  = p[W-1:0];

  p_div_identity_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (({{W{1'b0}}, quot_o} * {{W{1'b0}}, d_q} + {{W{1'b0}}, rem_o}) == {{W{1'b0}}, n_q})
               && (rem_o < d_q));
  p_div_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == DV_RUN) |-> !done_o);
endmodule

// File: rtl/modinv_coef.sv
module modinv_coef #(
  parameter int W = 32
) (
  input  logic signed [W:0] t_prev_i,
  input  logic signed [W:0] t_cur_i,
  input  logic [W-1:0]      quot_i,
  input  logic [W-1:0]      phi_i,
  output logic signed [W:0] t_next_o,
  output logic [W-1:0]      d_fix_o
);
  logic signed [W:0] prod, phi_ext;

  assign prod     = $signed({1'b0, quot_i}) * t_cur_i;
  assign t_next_o = t_prev_i - prod;
  assign phi_ext  = $signed({1'b0, phi_i});
  // coefficient lies in (-phi, phi): one addition folds it into range
  assign d_fix_o  = t_prev_i[W] ? W'(t_prev_i + phi_ext) : t_prev_i[W-1:0];
endmodule

// File: rtl/modinv_unit.sv
module modinv_unit #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] e_i,
  input  logic [W-1:0] phi_i,
  output logic [W-1:0] d_o,
  output logic         done_o,
  output logic         err_o
);
  import modinv_pkg::*;

  inv_state_t        state;
  logic [W-1:0]      r0, r1, phi_q, quot, rem, d_fix;
  logic signed [W:0] t0, t1, t_next;
  logic              div_start, div_done;

  modinv_nrdiv #(.W(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .dividend_i(r0), .divisor_i(r1),
    .quot_o(quot), .rem_o(rem), .done_o(div_done)
  );

  modinv_coef #(.W(W)) u_coef (
    .t_prev_i(t0), .t_cur_i(t1), .quot_i(quot), .phi_i(phi_q),
    .t_next_o(t_next), .d_fix_o(d_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      r0        <= '0;
      r1        <= '0;
      t0        <= '0;
      t1        <= '0;
      phi_q     <= '0;
      div_start <= 1'b0;
      d_o       <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      div_start <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          r0    <= phi_i;
          r1    <= e_i;
          t0    <= '0;
          t1    <= (W+1)'(1);
          phi_q <= phi_i;
          state <= ST_CHK;
        end
        ST_CHK: begin
          if (r1 == '0) state <= ST_FIN;
          else begin
            div_start <= 1'b1;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: if (div_done) begin
          r0    <= r1;
          r1    <= rem;
          t0    <= t1;
          t1    <= t_next;
          state <= ST_CHK;
        end
        ST_FIN: begin
          done_o <= 1'b1;
          if (r0 == W'(1)) begin
            d_o   <= d_fix;
            err_o <= 1'b0;
          end else begin
            d_o   <= '0;
            err_o <= 1'b1;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (d_o == '0));
  p_d_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (d_o < phi_q));
  p_ignore_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state != ST_IDLE) && start_i) |=> $stable(phi_q));
  p_hold_result_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_FIN) |=> ($stable(d_o) && $stable(err_o)));
endmodule

// File: tb/sim_modinv_unit.sv
module sim_modinv_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] e_in = '0, phi_in = '0;
  logic [W-1:0] d_out;
  logic         done, err;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  modinv_unit #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .e_i(e_in), .phi_i(phi_in),
    .d_o(d_out), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic void ref_inv(input int e, input int phi, output int d, output bit ok);
    ok = 1'b0;
    d  = 0;
    for (int k = 0; k < phi; k++)
      if ((e * k) % phi == 1) begin
        d  = k;
        ok = 1'b1;
        break;
      end
  endfunction

  task automatic pulse_start(input int e, input int phi);
    @(negedge clk);
    e_in   = W'(e);
    phi_in = W'(phi);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic run(input int e, input int phi, input string req);
    int  exp_d;
    bit  exp_ok, seen;
    int  d_seen;
    bit  e_seen;
    ref_inv(e, phi, exp_d, exp_ok);
    pulse_start(e, phi);
    wait_done(seen);
    chk(seen, {req, " done"}, int'(seen), 1);
    if (seen) begin
      // R2/R3 also confirm divider quotient/remainder (R6) through the final value
      chk(err == !exp_ok, {req, " err"}, int'(err), int'(!exp_ok));
      chk(int'(d_out) == exp_d, {req, " d"}, int'(d_out), exp_d);
      d_seen = int'(d_out);
      e_seen = err;
      @(negedge clk);
      chk(!done, "R4 pulse width", int'(done), 0);
      chk(int'(d_out) == d_seen && err == e_seen, "R4 hold", int'(d_out), d_seen);
    end
  endtask

  initial begin
    #(8 * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk(d_out == '0 && !done && !err, "R1 reset", int'(d_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(d_out == '0 && !done && !err, "R1 idle", int'(d_out), 0);

    for (int phi = 2; phi <= 30; phi++)
      for (int e = 0; e < phi; e++) begin
        int dd;
        bit ok;
        ref_inv(e, phi, dd, ok);
        if (e == 0) run(e, phi, "R8");
        else if (ok) run(e, phi, "R2");
        else run(e, phi, "R3");
      end

    for (int e = 1; e < 255; e += 7) run(e, 255, "R2 wide");
    for (int e = 1; e < 254; e += 11) run(e, 254, "R3 wide");
    run(254, 255, "R2 wide");
    run(253, 254, "R2 wide");

    // R7: exponents at or above phi
    run(17, 10, "R7");
    run(255, 7, "R7");
    run(200, 97, "R7");
    run(14, 14, "R7");
    run(30, 12, "R7");

    // R5: second start while running is dropped
    pulse_start(3, 10);
    repeat (5) @(negedge clk);
    e_in   = W'(4);
    phi_in = W'(10);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    wait_done(seen);
    chk(seen && !err && d_out == W'(7), "R5 first operands kept", int'(d_out), 7);
    begin
      bit extra = 1'b0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (done) extra = 1'b1;
      end
      chk(!extra, "R5 single done", int'(extra), 0);
      chk(d_out == W'(7), "R4 hold idle", int'(d_out), 7);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule